// File: doc/BRIEF.md
# Line Pulse Pattern Generator

This block produces one programmable pulse waveform inside every horizontal line of an image sensor timing engine. A 12-bit pixel counter runs from 0 up to a programmed line length and then wraps. A pattern pass begins when the pixel counter reaches a first start position. In each pass an 8-bit pattern counter counts from 0 up to a pattern length. The pulse edges fall where that counter matches two toggle values.

Two complete patterns are held on the inputs. Each has a length, a rising-edge toggle and a falling-edge toggle. Each of five sensor regions picks one of the two patterns with a select bit and sets how many extra passes follow the first. Each later pass starts a programmed pitch of pixels after the previous start. A pitch larger than the line therefore gives one pass per line, and a short pitch packs several passes into one line. The region choice is taken once per line, on the last pixel of the line before, so a line never mixes settings. An invert input flips the final output.

Top module: `line_pulse_gen`

## Requirements
- R1: The pixel counter resets to 0, steps by one per clock and wraps to 0 on the cycle after it equals `line_len_i`. This holds at the largest line length of 4095.
- R2: Pass k starts on the cycle where the pixel counter equals `start0_i` for k = 0 and `start0_i + k*pitch_i` otherwise. With tog1 < tog2 ≤ length, the pre-inversion pulse is high for pixel counts h with start+2+tog1 ≤ h < start+2+tog2. It never stays high past the line's last pixel.
- R3: The active region's select bit chooses the pattern for the line: 0 uses pattern index 0 of the `pat_*` arrays and 1 uses pattern index 1.
- R4: A line contains at most rep+1 passes, where rep is the active region's 2-bit repetition value (0 to 3).
- R5: A start position that lands on or beyond the last pixel of the line starts no pass. A pitch larger than the line therefore yields exactly one pass per line.
- R6: On wrap, the pattern counter, the pass count and the pulse clear, so every line begins from the same state.
- R7: The region settings are sampled only on the last pixel of a line and used for the whole next line. Changes to `region_i` at any other cycle have no effect on the output.
- R8: A sampled `region_i` value of 5 to 7 leaves the previous line's settings in force.
- R9: When `invert_i` is 1, `pulse_o` is the inverse of the generated pulse.
- R10: During and right after reset, the generated pulse is low, so `pulse_o` equals `invert_i`. The first line uses pattern 0 with rep 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_len_i | input | 12 | Last pixel count of a line |
| start0_i | input | 12 | Pixel count where the first pass starts |
| pitch_i | input | 12 | Pixel distance between consecutive pass starts |
| pat_len_i | input | 2x8 | Pattern counter end value, per pattern |
| pat_tog1_i | input | 2x8 | Count at which the pulse rises, per pattern |
| pat_tog2_i | input | 2x8 | Count at which the pulse falls, per pattern |
| region_i | input | 3 | Index of the region for the next line |
| region_sel_i | input | 5 | Pattern select bit, one per region |
| region_rep_i | input | 5x2 | Extra pass count, one per region |
| invert_i | input | 1 | Invert the output pulse |
| pulse_o | output | 1 | Line pulse output |

## Verification
The sweeps target several corner cases:
- A pass whose start lands exactly on the last pixel. A design that ignores the wrap priority would begin a stray pass there.
- A pitch exactly two longer than the pattern length. An off-by-one in the idle test would drop the later passes.
- A 255-count pattern, to catch an 8-bit counter overflow that would never end the pass.
- A 4095 line length, to catch a counter width or wrap error.
- A region index that changes in mid-line and region indices above 4. A design that samples at the wrong time, or decodes out-of-range indices, would switch patterns inside a line or load garbage settings.
- Rep values from 0 to 3, to expose a pass limit that is off by one.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int LP_HW   = 12;
    localparam int LP_PW   = 8;
    localparam int LP_NREG = 5;
    localparam int LP_RW   = 2;
    localparam int LP_NPAT = 2;

    typedef enum logic {
        PAT_FIRST  = 1'b0,
        PAT_SECOND = 1'b1
    } pat_sel_e;
endpackage

// File: rtl/lp_line_counter.sv
module lp_line_counter #(
    parameter int HW = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [HW-1:0] line_len_i,
    output logic [HW-1:0] hcnt_o,
    output logic          wrap_o
);
    localparam logic [HW-1:0] ONE = HW'(1);

    typedef struct packed {
        logic [HW-1:0] hcnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hcnt == line_len_i) begin
            st_d.hcnt = '0;
        end else begin
            st_d.hcnt = st_q.hcnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hcnt_o = st_q.hcnt;
    assign wrap_o = (st_q.hcnt == line_len_i);
endmodule

// File: rtl/lp_region_cfg.sv
module lp_region_cfg #(
    parameter int NREG = 5,
    parameter int RW   = 2,
    parameter int IDXW = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wrap_i,
    input  logic [IDXW-1:0]          region_i,
    input  logic [NREG-1:0]          sel_all_i,
    input  logic [NREG-1:0][RW-1:0]  rep_all_i,
    output lp_pkg::pat_sel_e         sel_o,
    output logic [RW-1:0]            rep_o
);
    typedef struct packed {
        lp_pkg::pat_sel_e sel;
        logic [RW-1:0]    rep;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            for (int r = 0; r < NREG; r++) begin
                if (region_i == IDXW'(r)) begin
                    st_d.sel = lp_pkg::pat_sel_e'(sel_all_i[r]);
                    st_d.rep = rep_all_i[r];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sel: lp_pkg::PAT_FIRST, rep: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;
    assign rep_o = st_q.rep;
endmodule

// File: rtl/lp_pass_engine.sv
module lp_pass_engine #(
    parameter int HW = 12,
    parameter int PW = 8,
    parameter int RW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [HW-1:0] hcnt_i,
    input  logic          wrap_i,
    input  logic [HW-1:0] start0_i,
    input  logic [HW-1:0] pitch_i,
    input  logic [PW-1:0] len_i,
    input  logic [PW-1:0] tog1_i,
    input  logic [PW-1:0] tog2_i,
    input  logic [RW-1:0] rep_i,
    output logic          pulse_o,
    output logic          active_o,
    output logic [PW-1:0] pcnt_o,
    output logic [RW:0]   passes_o
);
    localparam logic [PW-1:0] PONE = PW'(1);
    localparam logic [RW:0]   NONE = (RW + 1)'(1);

    typedef struct packed {
        logic          active;
        logic [PW-1:0] pcnt;
        logic [RW:0]   passes;
        logic [HW:0]   target;
        logic          pulse;
    } state_t;

    state_t st_d, st_q;
    logic   at_start;

    always_comb begin
        if (st_q.passes == '0) begin
            at_start = (hcnt_i == start0_i);
        end else begin
            at_start = ({1'b0, hcnt_i} == st_q.target);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.active = 1'b0;
            st_d.pcnt   = '0;
            st_d.passes = '0;
            st_d.pulse  = 1'b0;
        end else if (st_q.active) begin
            if (st_q.pcnt == len_i) begin
                st_d.active = 1'b0;
            end else begin
                st_d.pcnt = st_q.pcnt + PONE;
            end
            if (st_q.pcnt == tog1_i) begin
                st_d.pulse = 1'b1;
            end else if (st_q.pcnt == tog2_i) begin
                st_d.pulse = 1'b0;
            end
        end else if (at_start && (st_q.passes <= {1'b0, rep_i})) begin
            st_d.active = 1'b1;
            st_d.pcnt   = '0;
            st_d.passes = st_q.passes + NONE;
            st_d.target = {1'b0, hcnt_i} + {1'b0, pitch_i};
            st_d.pulse  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o  = st_q.pulse;
    assign active_o = st_q.active;
    assign pcnt_o   = st_q.pcnt;
    assign passes_o = st_q.passes;
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen #(
    parameter int HW   = lp_pkg::LP_HW,
    parameter int PW   = lp_pkg::LP_PW,
    parameter int NREG = lp_pkg::LP_NREG,
    parameter int RW   = lp_pkg::LP_RW,
    localparam int NPAT = lp_pkg::LP_NPAT,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [HW-1:0]            line_len_i,
    input  logic [HW-1:0]            start0_i,
    input  logic [HW-1:0]            pitch_i,
    input  logic [NPAT-1:0][PW-1:0]  pat_len_i,
    input  logic [NPAT-1:0][PW-1:0]  pat_tog1_i,
    input  logic [NPAT-1:0][PW-1:0]  pat_tog2_i,
    input  logic [IDXW-1:0]          region_i,
    input  logic [NREG-1:0]          region_sel_i,
    input  logic [NREG-1:0][RW-1:0]  region_rep_i,
    input  logic                     invert_i,
    output logic                     pulse_o
);
    logic [HW-1:0]    hcnt;
    logic             wrap;
    lp_pkg::pat_sel_e sel_cur;
    logic [RW-1:0]    rep_cur;
    logic [PW-1:0]    cur_len, cur_tog1, cur_tog2;
    logic             pulse_raw, active;
    logic [PW-1:0]    pcnt;
    logic [RW:0]      passes;

    lp_line_counter #(.HW(HW)) u_line (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .line_len_i (line_len_i),
        .hcnt_o     (hcnt),
        .wrap_o     (wrap)
    );

    lp_region_cfg #(.NREG(NREG), .RW(RW), .IDXW(IDXW)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wrap_i    (wrap),
        .region_i  (region_i),
        .sel_all_i (region_sel_i),
        .rep_all_i (region_rep_i),
        .sel_o     (sel_cur),
        .rep_o     (rep_cur)
    );

    assign cur_len  = pat_len_i[sel_cur];
    assign cur_tog1 = pat_tog1_i[sel_cur];
    assign cur_tog2 = pat_tog2_i[sel_cur];

    lp_pass_engine #(.HW(HW), .PW(PW), .RW(RW)) u_pass (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hcnt_i   (hcnt),
        .wrap_i   (wrap),
        .start0_i (start0_i),
        .pitch_i  (pitch_i),
        .len_i    (cur_len),
        .tog1_i   (cur_tog1),
        .tog2_i   (cur_tog2),
        .rep_i    (rep_cur),
        .pulse_o  (pulse_raw),
        .active_o (active),
        .pcnt_o   (pcnt),
        .passes_o (passes)
    );

    assign pulse_o = pulse_raw ^ invert_i;
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
    parameter int HW = 12,
    parameter int PW = 8,
    parameter int RW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [HW-1:0] line_len_i,
    input logic [HW-1:0] hcnt,
    input logic          active,
    input logic [PW-1:0] pcnt,
    input logic [PW-1:0] cur_len,
    input logic [RW:0]   passes,
    input logic [RW-1:0] rep_cur,
    input logic          sel_cur
);
    p_hcnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hcnt == line_len_i) |=> (hcnt == '0));

    p_hcnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hcnt != line_len_i) |=> (hcnt == HW'($past(hcnt) + HW'(1))));

    p_pcnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active |-> (pcnt <= cur_len));

    p_pass_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        passes <= ({1'b0, rep_cur} + (RW + 1)'(1)));

    p_wrap_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hcnt == line_len_i) |=> (!active && passes == '0));

    p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hcnt != line_len_i) |=> ($stable(sel_cur) && $stable(rep_cur)));
endmodule

bind line_pulse_gen lp_checker #(.HW(HW), .PW(PW), .RW(RW)) u_lp_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_len_i (line_len_i),
    .hcnt       (hcnt),
    .active     (active),
    .pcnt       (pcnt),
    .cur_len    (cur_len),
    .passes     (passes),
    .rep_cur    (rep_cur),
    .sel_cur    (sel_cur)
);

// File: tb/test_line_pulse_gen.sv
`timescale 1ns/1ps
module test_line_pulse_gen;
    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic [11:0]      line_len = '0, start0 = '0, pitch = '0;
    logic [1:0][7:0]  pat_len = '0, pat_t1 = '0, pat_t2 = '0;
    logic [2:0]       region = '0;
    logic [4:0]       sel_all = '0;
    logic [4:0][1:0]  rep_all = '0;
    logic             invert = 1'b0;
    logic             pulse;
    int               checks = 0;
    int               fails = 0;

    always #2 clk = ~clk;

    line_pulse_gen i_line_pulse_gen (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .line_len_i   (line_len),
        .start0_i     (start0),
        .pitch_i      (pitch),
        .pat_len_i    (pat_len),
        .pat_tog1_i   (pat_t1),
        .pat_tog2_i   (pat_t2),
        .region_i     (region),
        .region_sel_i (sel_all),
        .region_rep_i (rep_all),
        .invert_i     (invert),
        .pulse_o      (pulse)
    );

    task automatic check(input bit act, input bit exp, input string tag, input int h);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at pixel %0d: pulse=%0b expected %0b", tag, h, act, exp);
        end
    endtask

    // Pre-inversion level at pixel h (R2, R4, R5)
    function automatic bit exp_high(int h, int l, int s0, int p, int rep, int t1, int t2);
        for (int k = 0; k < 4; k++) begin
            int s = s0 + k * p;
            if (k <= rep && s < l && h >= s + 2 + t1 && h < s + 2 + t2 && h <= l) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int sched(int ln);
        return (ln * 3 + 1) % 8;
    endfunction

    task automatic run_cfg(input int l, input int s0, input int p, input bit inv,
                           input int lines, input string tag);
        int cur_sel = 0;
        int cur_rep = 0;
        bit kept = 1'b0;
        @(negedge clk);
        rst_ni   = 1'b0;
        line_len = 12'(l);
        start0   = 12'(s0);
        pitch    = 12'(p);
        invert   = inv;
        region   = 3'd0;
        repeat (3) @(negedge clk);
        check(pulse, inv, "R10", -1);
        rst_ni = 1'b1;
        for (int c = 0; c < lines * (l + 1); c++) begin
            int h = c % (l + 1);
            int ln = c / (l + 1);
            bit e;
            string t;
            if (h == 0 && ln > 0) begin
                kept = (sched(ln - 1) >= 5); // R8: out-of-range index keeps settings
                if (!kept) begin
                    cur_sel = int'(sel_all[sched(ln - 1)]);
                    cur_rep = int'(rep_all[sched(ln - 1)]);
                end
            end
            e = exp_high(h, l, s0, p, cur_rep, int'(pat_t1[cur_sel]),
                         int'(pat_t2[cur_sel])) ^ inv;
            if (ln == 0) t = "R10";
            else if (kept) t = "R8";
            else if (h < 3) t = "R6";
            else if (h < l / 2) t = "R7";
            else t = tag;
            check(pulse, e, t, h);
            if (h == 1) region = 3'((ln * 3 + 3) % 5);   // R7: mid-line change
            if (h == l / 2) region = 3'(sched(ln));
            @(negedge clk);
        end
    endtask

    initial begin
        sel_all = 5'b01101;
        rep_all = {2'd0, 2'd3, 2'd2, 2'd1, 2'd0};
        pat_len[0] = 8'd5; pat_t1[0] = 8'd1; pat_t2[0] = 8'd4;
        pat_len[1] = 8'd7; pat_t1[1] = 8'd0; pat_t2[1] = 8'd6;
        run_cfg(40, 3, 10, 1'b0, 12, "R2");     // R2 several passes, R3 both patterns
        run_cfg(40, 0, 9, 1'b1, 12, "R9");      // R9 invert, pitch = len+2
        run_cfg(30, 8, 60, 1'b0, 12, "R5");     // R5 one set per line
        run_cfg(50, 5, 15, 1'b0, 12, "R4");     // R4 start on last pixel dropped
        run_cfg(4095, 4000, 30, 1'b0, 4, "R1"); // R1 full-width line
        sel_all = 5'b11111;
        pat_len[0] = 8'd3;   pat_t1[0] = 8'd2;   pat_t2[0] = 8'd3;
        pat_len[1] = 8'd255; pat_t1[1] = 8'd100; pat_t2[1] = 8'd255;
        run_cfg(600, 10, 257, 1'b0, 12, "R3");  // R3 second pattern, 8-bit limit
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule